// File: doc/BRIEF.md
# Coprocessor Context Save Controller

This block sequences context save and restore for an arithmetic coprocessor that only ever answers the host and never drives the bus itself. The host raises an asynchronous request level. The block brings it across with a two-flop synchronizer and answers with a four-phase acknowledge. On a save request it picks a frame size from what the execution unit is doing. It then streams the frame out as 32-bit words on a valid/ready port, and the host drains that port at its own pace. On a restore request it takes a frame on a valid/ready input port, checks the leading format word, and writes the context words back into the execution unit.

There are three frame sizes. A unit still in its reset state gives a single null word. An idle unit gives a short 7-word frame. A unit in mid-operation is halted and gives the full 46-word frame. There is one exception to the full frame: when the unit reports fewer cycles left than the full frame has words, the block waits for the operation to finish and then sends the idle frame. The context words reach the unit through a simple word-addressed port. Save reads from it, and restore writes to it.

Back-pressure rules are the same on both streams. A word moves only on a cycle where valid and ready are both high. The output holds `out_valid` and `out_data` steady until the word is taken. The input drops `in_ready` as soon as the frame is complete or rejected, so any words the host still offers after that point are not consumed.

Top module: `ctxsv_top`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is held unchanged on the next cycle. Frame words leave in order: first the format word, then context words 0, 1, 2 and onward.
- R2: A rising edge on `save_req` or `rest_req`, after the two-flop synchronizer, starts one operation. Its acknowledge (`save_ack` or `rest_ack`) rises when the frame is done and stays high until the request has dropped. The two acknowledges are never high together. After reset, no acknowledge, no valid and no ready is asserted.
- R3: A save taken while the unit is in its reset state gives exactly one word. That word is the format word with a length of 0. The format word layout is: bits 31:24 hold the version 0x1F, bits 23:16 hold the number of bytes that follow the format word, and bits 15:0 are zero. `op_start` leaves the reset state.
- R4: A save taken while the unit is idle (`eu_busy` low) gives 7 words. The format word has length 0x18. It is followed by context words 0 to 5.
- R5: A save taken while the unit is busy with `eu_remaining` of at least 46 raises `eu_halt` for the whole transfer. It gives 46 words: the format word with length 0xB4, followed by context words 0 to 44.
- R6: A save taken while the unit is busy with `eu_remaining` below 46 does not halt the unit. The block waits until `eu_busy` falls and then gives the 7-word idle frame. At 45 the result is the idle frame; at 46 and at 47 it is the full frame.
- R7: A restore whose format word carries length 0 consumes that one word and puts the unit back in its reset state, so the next save gives the 1-word null frame.
- R8: A restore of a valid idle or full frame writes the words that follow the format word into context words 0 to N-2, in order. After a full frame it pulses `eu_resume` for one cycle. An idle frame causes no pulse and leaves word 6 and above untouched.
- R9: A restore whose format word has a version other than 0x1F, a length outside {0x00, 0x18, 0xB4}, or nonzero low bits raises `proto_err`. Such a frame causes no context write and no `eu_resume`. `proto_err` clears when the next restore request is taken.
- R10: During a save, `in_ready` stays low. During a restore, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coprocessor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_req | input | 1 | Asynchronous save request level from the host |
| save_ack | output | 1 | Save done; held until save_req drops |
| rest_req | input | 1 | Asynchronous restore request level from the host |
| rest_ack | output | 1 | Restore done; held until rest_req drops |
| op_start | input | 1 | Pulse from decode when an operation starts; leaves the reset state |
| eu_busy | input | 1 | Execution unit has an operation in flight |
| eu_remaining | input | CNT_W | Cycles left in the operation in flight |
| eu_halt | output | 1 | Freeze the operation in flight while a full frame is saved |
| eu_resume | output | 1 | One-cycle pulse to resume after a full frame is restored |
| ctx_addr | output | AW | Context word index |
| ctx_rdata | input | 32 | Context word read at ctx_addr |
| ctx_wdata | output | 32 | Context word to write |
| ctx_we | output | 1 | Context write strobe |
| out_valid | output | 1 | Save stream word valid |
| out_ready | input | 1 | Host takes the save stream word |
| out_data | output | 32 | Save stream word |
| in_valid | input | 1 | Restore stream word valid |
| in_ready | output | 1 | Block accepts the restore stream word |
| in_data | input | 32 | Restore stream word |
| proto_err | output | 1 | Last restore frame was rejected |

## Verification
The assertions assume that the context read data is stable for as long as a save frame is being drained. They also assume that `eu_remaining` only counts down while `eu_halt` is low, so the value sampled when the halt begins is the value the size decision was made on. The bench models the execution unit so that both assumptions hold. Its context store changes only through `ctx_we` or between operations. Its countdown is frozen while a request is being synchronized and is released only after the size decision has been made. That is what makes the threshold cases at 45, 46 and 47 land exactly.

// File: rtl/ctxsv_pkg.sv
package ctxsv_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {K_NULL, K_IDLE, K_FULL} kind_e;

  // format word: version, bytes following the format word, zero low half
  function automatic logic [WORD_W-1:0] fmt_word(input logic [7:0] ver, input int words);
    return {ver, 8'((words - 1) * 4), 16'h0000};
  endfunction
endpackage

// File: rtl/ctxsv_sync.sv
module ctxsv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ctxsv_sizer.sv
module ctxsv_sizer
  import ctxsv_pkg::*;
#(
  parameter int FULL_WORDS = 46,
  parameter int CNT_W      = 16
) (
  input  logic             null_st,
  input  logic             eu_busy,
  input  logic [CNT_W-1:0] eu_remaining,
  output kind_e            kind,
  output logic             must_wait
);
  always_comb begin
    must_wait = 1'b0;
    if (null_st)      kind = K_NULL;
    else if (!eu_busy) kind = K_IDLE;
    else if (eu_remaining < CNT_W'(FULL_WORDS)) begin
      kind      = K_IDLE;
      must_wait = 1'b1;
    end else          kind = K_FULL;
  end
endmodule

// File: rtl/ctxsv_fmtchk.sv
module ctxsv_fmtchk
  import ctxsv_pkg::*;
#(
  parameter logic [7:0] VERSION    = 8'h1F,
  parameter int         IDLE_WORDS = 7,
  parameter int         FULL_WORDS = 46
) (
  input  logic [WORD_W-1:0] word,
  output logic              ok,
  output kind_e             kind
);
  localparam logic [7:0] L_IDLE = 8'((IDLE_WORDS - 1) * 4);
  localparam logic [7:0] L_FULL = 8'((FULL_WORDS - 1) * 4);

  logic [7:0] len;
  logic       hdr_ok;

  assign len    = word[23:16];
  assign hdr_ok = (word[31:24] == VERSION) && (word[15:0] == 16'h0000);

  always_comb begin
    ok   = hdr_ok;
    kind = K_NULL;
    if (len == L_IDLE)      kind = K_IDLE;
    else if (len == L_FULL) kind = K_FULL;
    else if (len != 8'h00)  ok = 1'b0;
  end
endmodule

// File: rtl/ctxsv_top.sv
module ctxsv_top
  import ctxsv_pkg::*;
#(
  parameter int         IDLE_WORDS = 7,
  parameter int         FULL_WORDS = 46,
  parameter int         CNT_W      = 16,
  parameter logic [7:0] VERSION    = 8'h1F,
  localparam int        AW         = $clog2(FULL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  output logic              save_ack,
  input  logic              rest_req,
  output logic              rest_ack,
  input  logic              op_start,
  input  logic              eu_busy,
  input  logic [CNT_W-1:0]  eu_remaining,
  output logic              eu_halt,
  output logic              eu_resume,
  output logic [AW-1:0]     ctx_addr,
  input  logic [31:0]       ctx_rdata,
  output logic [31:0]       ctx_wdata,
  output logic              ctx_we,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              proto_err
);
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SEND, S_RECV, S_ACK} st_e;

  localparam logic [AW-1:0] LAST_IDLE = AW'(IDLE_WORDS - 1);
  localparam logic [AW-1:0] LAST_FULL = AW'(FULL_WORDS - 1);

  st_e           st;
  kind_e         kind, sz_kind, fc_kind;
  logic [AW-1:0] idx, last_idx;
  logic          null_st, is_save, sz_wait, fc_ok;
  logic          save_s, rest_s, save_q, rest_q, save_rise, rest_rise;
  logic          out_beat, in_beat;

  ctxsv_sync #(.STAGES(2)) u_sync_save (.clk(clk), .rst_n(rst_n), .d(save_req), .q(save_s));
  ctxsv_sync #(.STAGES(2)) u_sync_rest (.clk(clk), .rst_n(rst_n), .d(rest_req), .q(rest_s));

  ctxsv_sizer #(.FULL_WORDS(FULL_WORDS), .CNT_W(CNT_W)) u_sizer (
    .null_st(null_st), .eu_busy(eu_busy), .eu_remaining(eu_remaining),
    .kind(sz_kind), .must_wait(sz_wait));

  ctxsv_fmtchk #(.VERSION(VERSION), .IDLE_WORDS(IDLE_WORDS), .FULL_WORDS(FULL_WORDS)) u_fmt (
    .word(in_data), .ok(fc_ok), .kind(fc_kind));

  assign save_rise = save_s & ~save_q;
  assign rest_rise = rest_s & ~rest_q;
  assign out_beat  = out_valid & out_ready;
  assign in_beat   = in_valid & in_ready;

  always_comb begin
    case (kind)
      K_IDLE:  last_idx = LAST_IDLE;
      K_FULL:  last_idx = LAST_FULL;
      default: last_idx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_NULL;
      idx       <= '0;
      null_st   <= 1'b1;
      is_save   <= 1'b0;
      proto_err <= 1'b0;
      eu_resume <= 1'b0;
      save_q    <= 1'b0;
      rest_q    <= 1'b0;
    end else begin
      save_q    <= save_s;
      rest_q    <= rest_s;
      eu_resume <= 1'b0;
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (save_rise) begin
            is_save <= 1'b1;
            kind    <= sz_kind;
            st      <= sz_wait ? S_WAIT : S_SEND;
          end else if (rest_rise) begin
            is_save   <= 1'b0;
            proto_err <= 1'b0;
            st        <= S_RECV;
          end else if (op_start) begin
            null_st <= 1'b0;
          end
        end
        S_WAIT: if (!eu_busy) st <= S_SEND;
        S_SEND: if (out_beat) begin
          if (idx == last_idx) begin
            st  <= S_ACK;
            idx <= '0;
          end else idx <= idx + AW'(1);
        end
        S_RECV: if (in_beat) begin
          if (idx == '0) begin
            if (!fc_ok) begin
              proto_err <= 1'b1;
              st        <= S_ACK;
            end else if (fc_kind == K_NULL) begin
              null_st <= 1'b1;
              st      <= S_ACK;
            end else begin
              kind <= fc_kind;
              idx  <= AW'(1);
            end
          end else if (idx == last_idx) begin
            null_st   <= 1'b0;
            eu_resume <= (kind == K_FULL);
            idx       <= '0;
            st        <= S_ACK;
          end else idx <= idx + AW'(1);
        end
        S_ACK: if (is_save ? !save_s : !rest_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign out_valid = (st == S_SEND);
  assign in_ready  = (st == S_RECV);
  assign save_ack  = (st == S_ACK) && is_save;
  assign rest_ack  = (st == S_ACK) && !is_save;
  assign eu_halt   = ((st == S_SEND) || (st == S_ACK)) && is_save && (kind == K_FULL);
  assign ctx_addr  = idx - AW'(1);
  assign ctx_wdata = in_data;
  assign ctx_we    = in_beat && (idx != '0);
  assign out_data  = (idx == '0)
                   ? fmt_word(VERSION, (kind == K_NULL) ? 1 : (kind == K_IDLE) ? IDLE_WORDS : FULL_WORDS)
                   : ctx_rdata;
endmodule

// File: rtl/ctxsv_chk.sv
module ctxsv_chk #(
  parameter int FULL_WORDS = 46,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             in_ready,
  input logic             eu_halt,
  input logic [CNT_W-1:0] eu_remaining,
  input logic             eu_resume,
  input logic             proto_err,
  input logic             ctx_we,
  input logic             save_ack,
  input logic             rest_ack
);
  // R1: stalled word is held
  a_r1_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2: at most one acknowledge at a time
  a_r2_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_ack, rest_ack}));

  // R6: a halt only starts when the remaining count reached the threshold
  a_r6_halt_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eu_halt) |-> $past(eu_remaining) >= CNT_W'(FULL_WORDS));

  // R8: resume is a single-cycle pulse
  a_r8_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eu_resume |=> !eu_resume);

  // R9: a rejected frame writes nothing
  a_r9_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !ctx_we && !eu_resume);

  // R10: streams are never active together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));
endmodule

bind ctxsv_top ctxsv_chk #(.FULL_WORDS(FULL_WORDS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .in_ready(in_ready), .eu_halt(eu_halt),
  .eu_remaining(eu_remaining), .eu_resume(eu_resume), .proto_err(proto_err),
  .ctx_we(ctx_we), .save_ack(save_ack), .rest_ack(rest_ack));

// File: tb/ctxsv_top_tb.sv
module ctxsv_top_tb;
  localparam int NW = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_req = 0, rest_req = 0, op_start = 0, eu_busy = 0, run = 0;
  logic [15:0] eu_remaining = '0;
  logic save_ack, rest_ack, eu_halt, eu_resume, ctx_we, out_valid, in_ready, proto_err;
  logic out_ready = 0, in_valid = 0;
  logic [5:0]  ctx_addr;
  logic [31:0] ctx_rdata, ctx_wdata, out_data, in_data = '0;

  logic [31:0] mem [0:NW-1];
  logic [31:0] orig [0:NW-1];
  logic [31:0] cap [0:63];
  logic [31:0] frm [0:63];

  int checks = 0, errors = 0, cycles = 0;
  bit saw_halt, saw_inready, saw_resume, busy_first;

  always #10 clk = ~clk;

  ctxsv_top u_dut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_ack(save_ack),
    .rest_req(rest_req), .rest_ack(rest_ack), .op_start(op_start),
    .eu_busy(eu_busy), .eu_remaining(eu_remaining), .eu_halt(eu_halt),
    .eu_resume(eu_resume), .ctx_addr(ctx_addr), .ctx_rdata(ctx_rdata),
    .ctx_wdata(ctx_wdata), .ctx_we(ctx_we), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .proto_err(proto_err));

  assign ctx_rdata = (ctx_addr < NW) ? mem[ctx_addr] : 32'h0;

  // execution unit model: context store and countdown
  always @(posedge clk) begin
    if (ctx_we && ctx_addr < NW) mem[ctx_addr] <= ctx_wdata;
    if (run && eu_busy && !eu_halt) begin
      if (eu_remaining <= 16'd1) begin
        eu_busy      <= 1'b0;
        eu_remaining <= '0;
      end else eu_remaining <= eu_remaining - 16'd1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  function automatic logic [31:0] exp_fmt(input int words);
    return {8'h1F, 8'((words - 1) * 4), 16'h0000};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_save(input bit bp, input bit release_run, output int n);
    int cyc = 0;
    n = 0; saw_halt = 0; saw_inready = 0; busy_first = 0;
    @(negedge clk); save_req = 1;
    while (!save_ack && cyc < 3000) begin
      @(negedge clk);
      if (release_run && cyc == 6) run = 1;
      out_ready = bp ? cyc[0] : 1'b1;
      if (eu_halt) saw_halt = 1;
      if (in_ready) saw_inready = 1;
      if (out_valid && out_ready) begin
        if (n == 0) busy_first = eu_busy;
        if (n < 64) cap[n] = out_data;
        n++;
      end
      cyc++;
    end
    out_ready = 0; save_req = 0; cyc = 0;
    while (save_ack && cyc < 100) begin @(negedge clk); cyc++; end
  endtask

  task automatic do_restore(input int nw);
    int k = 0, cyc = 0;
    saw_resume = 0;
    @(negedge clk); rest_req = 1;
    while (!rest_ack && cyc < 3000) begin
      @(negedge clk);
      if (eu_resume) saw_resume = 1;
      if (rest_ack) break;
      in_valid = (k < nw);
      in_data  = (k < 64) ? frm[k] : 32'h0;
      if (in_valid && in_ready) k++;
      cyc++;
    end
    @(negedge clk); if (eu_resume) saw_resume = 1;
    in_valid = 0; rest_req = 0; cyc = 0;
    while (rest_ack && cyc < 100) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    int n;
    bit ok;
    for (int i = 0; i < NW; i++) mem[i] = 32'hA500_0000 + i * 32'h0101_0101;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(!save_ack && !rest_ack && !out_valid && !in_ready, "R2", "reset outputs",
        {save_ack, rest_ack, out_valid, in_ready}, 0);
    chk(!proto_err && !eu_halt, "R9", "reset err/halt", {proto_err, eu_halt}, 0);

    // R3 null frame
    do_save(0, 0, n);
    chk(n == 1, "R3", "null length", n, 1);
    chk(cap[0] == exp_fmt(1), "R3", "null format word", cap[0], exp_fmt(1));
    chk(!save_ack, "R2", "ack released after request drop", save_ack, 0);
    chk(!saw_inready, "R10", "in_ready during save", saw_inready, 0);

    // R4 idle frame
    @(negedge clk); op_start = 1; @(negedge clk); op_start = 0;
    do_save(0, 0, n);
    chk(n == 7, "R4", "idle length", n, 7);
    chk(cap[0] == exp_fmt(7), "R4", "idle format word", cap[0], exp_fmt(7));
    ok = 1; for (int i = 1; i < 7; i++) if (cap[i] != mem[i-1]) ok = 0;
    chk(ok, "R4", "idle words", ok, 1);

    // R1 back-pressure on an idle frame
    do_save(1, 0, n);
    ok = (n == 7) && cap[0] == exp_fmt(7);
    for (int i = 1; i < 7; i++) if (cap[i] != mem[i-1]) ok = 0;
    chk(ok, "R1", "idle frame under back-pressure", n, 7);

    // R5/R6 threshold sweep
    for (int r = 40; r <= 52; r++) begin
      @(negedge clk); eu_busy = 1; run = 0; eu_remaining = 16'(r);
      do_save(0, 1, n);
      if (r < 46) begin
        chk(n == 7, "R6", $sformatf("finish-first length rem=%0d", r), n, 7);
        chk(!busy_first && !saw_halt, "R6", $sformatf("done before frame rem=%0d", r),
            {busy_first, saw_halt}, 0);
      end else begin
        chk(n == 46 && cap[0] == exp_fmt(46), "R6",
            $sformatf("full frame rem=%0d", r), n, 46);
        chk(saw_halt, "R5", $sformatf("halt rem=%0d", r), saw_halt, 1);
      end
      @(negedge clk); run = 0; eu_busy = 0; eu_remaining = '0;
    end

    // R5 full frame contents under back-pressure
    @(negedge clk); eu_busy = 1; eu_remaining = 16'd300;
    do_save(1, 0, n);
    ok = (n == 46) && cap[0] == exp_fmt(46);
    for (int i = 1; i < 46; i++) if (cap[i] != mem[i-1]) ok = 0;
    chk(ok, "R5", "full frame words", n, 46);
    chk(ok, "R1", "full frame order under back-pressure", ok, 1);

    // R8 round trip
    for (int i = 0; i < 46; i++) frm[i] = cap[i];
    for (int i = 0; i < NW; i++) begin orig[i] = mem[i]; mem[i] = ~mem[i]; end
    @(negedge clk); eu_busy = 0; eu_remaining = '0;
    do_restore(46);
    ok = 1; for (int i = 0; i < NW; i++) if (mem[i] != orig[i]) ok = 0;
    chk(ok, "R8", "round trip state", ok, 1);
    chk(saw_resume, "R8", "resume after full restore", saw_resume, 1);

    // R8 idle restore
    frm[0] = exp_fmt(7);
    for (int i = 1; i < 7; i++) frm[i] = 32'h5A5A_0000 + i;
    do_restore(7);
    ok = 1; for (int i = 0; i < 6; i++) if (mem[i] != 32'h5A5A_0001 + i) ok = 0;
    chk(ok, "R8", "idle restore words", ok, 1);
    chk(mem[6] == orig[6], "R8", "word 6 untouched", mem[6], orig[6]);
    chk(!saw_resume, "R8", "no resume after idle restore", saw_resume, 0);

    // R9 bad version and bad length
    for (int i = 0; i < NW; i++) orig[i] = mem[i];
    frm[0] = {8'h2E, 8'h18, 16'h0}; frm[1] = 32'hDEAD_BEEF;
    do_restore(7);
    chk(proto_err, "R9", "bad version flag", proto_err, 1);
    frm[0] = {8'h1F, 8'h10, 16'h0};
    do_restore(7);
    ok = 1; for (int i = 0; i < NW; i++) if (mem[i] != orig[i]) ok = 0;
    chk(proto_err && ok, "R9", "bad length flag, state kept", {proto_err, ok}, 3);
    frm[0] = exp_fmt(7); for (int i = 1; i < 7; i++) frm[i] = orig[i-1];
    do_restore(7);
    chk(!proto_err, "R9", "flag cleared by good restore", proto_err, 0);

    // R7 null restore
    frm[0] = exp_fmt(1);
    do_restore(1);
    do_save(0, 0, n);
    chk(n == 1 && cap[0] == exp_fmt(1), "R7", "null after null restore", n, 1);
    @(negedge clk); op_start = 1; @(negedge clk); op_start = 0;
    do_save(0, 0, n);
    chk(n == 7, "R3", "op_start leaves reset state", n, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule